// File: doc/BRIEF.md
# Unaligned Load Splitter

This block sits between a processor's load unit and a 32-bit little-endian data bus. The bus accepts only naturally aligned 8-, 16- and 32-bit transfers. A load request carries a byte address and an access size. When the address is not aligned to that size, the block does not reject the load. It issues a short, fixed series of aligned byte and halfword transfers, one at a time, and holds each one until the bus signals ready. As each transfer completes, its bytes are steered from their bus lanes into the right positions of a result word. When the last piece arrives, the block returns the assembled value to the requester in a single response.

The request side uses a valid/ready handshake. While a sequence is in flight, the request side is held not-ready. The response is a one-cycle valid pulse. In that same cycle the block is already idle again, so a new request can be taken with no gap. A transfer on the bus completes in the cycle in which the block drives a transfer and the bus raises ready. Read data is sampled in that same cycle.

Top module: `unaligned_load_splitter`

## Requirements
- R1: Every bus transfer is naturally aligned to its size, using size codes 0 = byte, 1 = halfword, 2 = word. A halfword transfer has address bit 0 clear. A word transfer has address bits 1:0 clear.
- R2: A word load (request size code 2) whose address A has low bits 00 is issued as one word transfer at A.
- R3: A word load with low address bits 01 or 11 is issued as three transfers, in this order: a byte at A, a halfword at A+1, then a byte at A+3.
- R4: A word load with low address bits 10 is issued as two halfword transfers: first at A, then at A+2.
- R5: A halfword load (size code 1) at an odd address is issued as two byte transfers, at A and then at A+1. A halfword load at an even address, and any byte load (size code 0), is issued as one transfer at A with the request's own size.
- R6: Byte i of the response holds the memory byte at A+i. Each piece of data is taken from the bus lane equal to that transfer's address modulo 4, counting upward. Lanes outside the transfer are ignored. Response bytes above the request size read as zero.
- R7: A transfer keeps its address and size until it completes with bus ready high. The next transfer of the sequence is driven in the following cycle.
- R8: Request ready is high exactly when no sequence is in flight. A request is taken when valid and ready are both high, and its first transfer is driven in the next cycle.
- R9: The response valid is a single-cycle pulse in the cycle after the final transfer completes. Request ready is high in that same cycle, so a back-to-back request is accepted at the end of it.
- R10: After reset, request ready is high, and both the transfer strobe and the response valid are low.
- R11: Request size code 3 is handled exactly like a word load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| rsp_valid | output | 1 | One-cycle pulse with the completed result |
| rsp_data | output | 32 | Assembled little-endian result, zero-extended |
| bus_trans | output | 1 | A bus transfer is being driven |
| bus_addr | output | ADDR_W | Address of the current transfer |
| bus_size | output | 2 | Size code of the current transfer |
| bus_ready | input | 1 | Current transfer completes this cycle |
| bus_rdata | input | 32 | Read data, four byte lanes |

## Verification
Two events can fall in the same cycle: the response pulse of one load and the acceptance of the next request. The bench provokes this by presenting a new request in exactly the cycle the response is expected. It then checks three things: the old result is intact, request ready is high, and the new load's first transfer appears on the following cycle with no idle gap. Bus ready is stalled by a pseudo-random pattern, so that held transfers and step advances land on varied cycles. Lanes outside each transfer carry a filler byte, which must never appear in a result.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // One step of a split sequence: byte offset from the request address,
  // transfer size, and whether it is the final step.
  typedef struct packed {
    logic [1:0] offs;
    logic [1:0] size;
    logic       last;
  } step_t;

  function automatic step_t mk_step(logic [1:0] offs, logic [1:0] size, logic last);
    step_t s;
    s.offs = offs;
    s.size = size;
    s.last = last;
    return s;
  endfunction

  function automatic logic [2:0] size_bytes(logic [1:0] size);
    case (size)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/split_planner.sv
module split_planner
  import splitter_pkg::*;
(
  input  logic [1:0] off,
  input  logic [1:0] req_size,
  input  logic [1:0] idx,
  output step_t      step
);
  always_comb begin
    step = mk_step(2'd0, SZ_WORD, 1'b1);
    if (req_size == SZ_BYTE) begin
      step = mk_step(2'd0, SZ_BYTE, 1'b1);
    end else if (req_size == SZ_HALF) begin
      if (off[0]) begin
        step = (idx == 2'd0) ? mk_step(2'd0, SZ_BYTE, 1'b0)
                             : mk_step(2'd1, SZ_BYTE, 1'b1);
      end else begin
        step = mk_step(2'd0, SZ_HALF, 1'b1);
      end
    end else begin
      case (off)
        2'd0: step = mk_step(2'd0, SZ_WORD, 1'b1);
        2'd2: step = (idx == 2'd0) ? mk_step(2'd0, SZ_HALF, 1'b0)
                                   : mk_step(2'd2, SZ_HALF, 1'b1);
        default: begin
          case (idx)
            2'd0:    step = mk_step(2'd0, SZ_BYTE, 1'b0);
            2'd1:    step = mk_step(2'd1, SZ_HALF, 1'b0);
            default: step = mk_step(2'd3, SZ_BYTE, 1'b1);
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/lane_gather.sv
module lane_gather
  import splitter_pkg::*;
(
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic [1:0]        pos,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] merged
);
  logic [2:0] nbytes;
  assign nbytes = size_bytes(size);

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    logic [2:0] rel;
    logic [1:0] src;
    logic       hit;
    assign rel = 3'(i) - {1'b0, pos};
    assign hit = (3'(i) >= {1'b0, pos}) && (rel < nbytes);
    assign src = lane + rel[1:0];
    assign merged[8*i +: 8] = hit ? rdata[{src, 3'b000} +: 8] : cur[8*i +: 8];
  end
endmodule

// File: rtl/unaligned_load_splitter.sv
module unaligned_load_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_trans,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);
  typedef enum logic {ST_IDLE, ST_XFER} state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        rsize_q;
  logic [1:0]        step_q;
  logic [1:0]        pos_q;
  logic              last_q;
  logic [DATA_W-1:0] result_q;
  logic              rsp_valid_q;
  logic              trans_q;
  logic [ADDR_W-1:0] baddr_q;
  logic [1:0]        bsize_q;

  logic              idle;
  logic              accept;
  logic              done_xfer;
  logic [1:0]        plan_off;
  logic [1:0]        plan_size;
  logic [1:0]        plan_idx;
  step_t             plan;
  logic [DATA_W-1:0] merged;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && req_valid;
  assign done_xfer = (state_q == ST_XFER) && bus_ready;

  assign plan_off  = idle ? req_addr[1:0] : base_q[1:0];
  assign plan_size = idle ? req_size : rsize_q;
  assign plan_idx  = idle ? 2'd0 : step_q + 2'd1;

  split_planner u_planner (
    .off      (plan_off),
    .req_size (plan_size),
    .idx      (plan_idx),
    .step     (plan)
  );

  lane_gather u_gather (
    .lane   (baddr_q[1:0]),
    .size   (bsize_q),
    .pos    (pos_q),
    .rdata  (bus_rdata),
    .cur    (result_q),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      rsize_q     <= SZ_BYTE;
      step_q      <= '0;
      pos_q       <= '0;
      last_q      <= 1'b0;
      result_q    <= '0;
      rsp_valid_q <= 1'b0;
      trans_q     <= 1'b0;
      baddr_q     <= '0;
      bsize_q     <= SZ_BYTE;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        state_q  <= ST_XFER;
        base_q   <= req_addr;
        rsize_q  <= req_size;
        step_q   <= 2'd0;
        result_q <= '0;
        trans_q  <= 1'b1;
        baddr_q  <= req_addr + ADDR_W'(plan.offs);
        bsize_q  <= plan.size;
        pos_q    <= plan.offs;
        last_q   <= plan.last;
      end else if (done_xfer) begin
        result_q <= merged;
        if (last_q) begin
          state_q     <= ST_IDLE;
          trans_q     <= 1'b0;
          rsp_valid_q <= 1'b1;
        end else begin
          step_q  <= step_q + 2'd1;
          baddr_q <= base_q + ADDR_W'(plan.offs);
          bsize_q <= plan.size;
          pos_q   <= plan.offs;
          last_q  <= plan.last;
        end
      end
    end
  end

  assign req_ready = idle;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = result_q;
  assign bus_trans = trans_q;
  assign bus_addr  = baddr_q;
  assign bus_size  = bsize_q;

  // R1: transfers are naturally aligned and use a legal size code
  p_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    bus_trans |-> (bus_size != 2'd3) &&
                  !((bus_size == SZ_WORD) && (bus_addr[1:0] != 2'b00)) &&
                  !((bus_size == SZ_HALF) && bus_addr[0]));

  // R7: a stalled transfer holds address and size
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_trans && !bus_ready) |=> bus_trans && $stable(bus_addr) && $stable(bus_size));

  // R8: no request is taken while a transfer is in flight
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    bus_trans |-> !req_ready);

  // R9: the response is a single-cycle pulse following a completed transfer
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> req_ready && !bus_trans);

  // R8: an accepted request starts a transfer on the next cycle
  p_start_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> bus_trans);
endmodule

// File: tb/unaligned_load_splitter_tb_top.sv
module unaligned_load_splitter_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          bus_trans;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          bus_ready;
  logic [31:0]   bus_rdata;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  logic [7:0] lfsr = 8'hA7;

  always #4 clk = ~clk;

  unaligned_load_splitter #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .bus_trans (bus_trans),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [7:0] mb(logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int nb(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  // Memory row response: selected lanes carry memory, the rest a filler byte
  task automatic drive_row;
    logic [AW-1:0] row;
    int lo;
    int n;
    row = {bus_addr[AW-1:2], 2'b00};
    lo  = int'(bus_addr[1:0]);
    n   = nb(bus_size);
    for (int l = 0; l < 4; l++) begin
      bus_rdata[8*l +: 8] = (l >= lo && l < lo + n) ? mb(row + AW'(l)) : 8'hEE;
    end
  endtask

  // Reference model: greedy largest-aligned split, expected little-endian result
  task automatic load(input logic [AW-1:0] a, input logic [1:0] sz, input bit preacc,
                      input bit chain, input logic [AW-1:0] na, input logic [1:0] nsz,
                      input string req);
    logic [AW-1:0] ea [4];
    logic [1:0]    es [4];
    int            n = 0;
    int            rem;
    logic [AW-1:0] cur;
    logic [31:0]   exp_data = '0;
    int            j = 0;
    bit            rdy;
    rem = nb(sz);
    cur = a;
    for (int i = 0; i < rem; i++) exp_data[8*i +: 8] = mb(a + AW'(i));
    while (rem > 0) begin
      if (cur[1:0] == 2'b00 && rem >= 4) begin ea[n] = cur; es[n] = 2'd2; cur += 4; rem -= 4; end
      else if (!cur[0] && rem >= 2)      begin ea[n] = cur; es[n] = 2'd1; cur += 2; rem -= 2; end
      else                               begin ea[n] = cur; es[n] = 2'd0; cur += 1; rem -= 1; end
      n++;
    end
    if (!preacc) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = sz;
      check(req_ready == 1'b1, "R8", "req_ready idle", 64'(req_ready), 1);
      @(posedge clk);
    end
    while (j < n) begin
      @(negedge clk);
      req_valid = 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = lfsr[0] | lfsr[1];
      bus_ready = rdy;
      drive_row();
      check(bus_trans == 1'b1, req, "bus_trans", 64'(bus_trans), 1);
      check(bus_addr == ea[j], req, $sformatf("step %0d addr", j), 64'(bus_addr), 64'(ea[j]));
      check(bus_size == es[j], req, $sformatf("step %0d size", j), 64'(bus_size), 64'(es[j]));
      check(!req_ready && !rsp_valid, "R8", "busy handshake", {req_ready, rsp_valid}, 0);
      @(posedge clk);
      if (rdy) j++;
    end
    @(negedge clk);
    bus_ready = 1'b0;
    bus_rdata = 32'hDEAD_BEEF;
    check(rsp_valid == 1'b1, "R9", "rsp_valid pulse", 64'(rsp_valid), 1);
    check(rsp_data == exp_data, "R6", "rsp_data", 64'(rsp_data), 64'(exp_data));
    check(req_ready && !bus_trans, "R9", "idle at response", {req_ready, bus_trans}, 2);
    if (chain) begin
      req_valid = 1'b1; req_addr = na; req_size = nsz;
    end
    @(posedge clk);
    if (!chain) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R9", "pulse ends", 64'(rsp_valid), 0);
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = 2'd0;
    bus_ready = 1'b0; bus_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(req_ready == 1'b1, "R10", "reset req_ready", 64'(req_ready), 1);
    check(bus_trans == 1'b0, "R10", "reset bus_trans", 64'(bus_trans), 0);
    check(rsp_valid == 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 0);

    load(32'h0000_0100, 2'd2, 0, 0, '0, 2'd0, "R2");
    load(32'h0000_0101, 2'd2, 0, 0, '0, 2'd0, "R3");
    load(32'h0000_0102, 2'd2, 0, 0, '0, 2'd0, "R4");
    load(32'h0000_0103, 2'd2, 0, 0, '0, 2'd0, "R3");
    load(32'h0000_01FF, 2'd2, 0, 0, '0, 2'd0, "R3");
    load(32'h0000_1005, 2'd2, 0, 0, '0, 2'd0, "R1");
    load(32'h0000_2000, 2'd1, 0, 0, '0, 2'd0, "R5");
    load(32'h0000_2001, 2'd1, 0, 0, '0, 2'd0, "R5");
    load(32'h0000_2002, 2'd1, 0, 0, '0, 2'd0, "R5");
    load(32'h0000_2003, 2'd1, 0, 0, '0, 2'd0, "R5");
    for (int k = 0; k < 4; k++) load(32'h0000_3040 + AW'(k), 2'd0, 0, 0, '0, 2'd0, "R5");
    load(32'h0000_4007, 2'd3, 0, 0, '0, 2'd0, "R11");
    load(32'h0000_4008, 2'd3, 0, 0, '0, 2'd0, "R11");
    // R9: back-to-back request presented in the response cycle
    load(32'h0000_5001, 2'd2, 0, 1, 32'h0000_5102, 2'd2, "R7");
    load(32'h0000_5102, 2'd2, 1, 1, 32'h0000_5203, 2'd1, "R9");
    load(32'h0000_5203, 2'd1, 1, 0, '0, 2'd0, "R9");
    for (int k = 0; k < 24; k++) begin
      load(32'h0001_0000 + AW'(k * 7), 2'(k % 3), 0, 0, '0, 2'd0, "R6");
    end
    repeat (2) @(negedge clk);
    check(bus_trans == 1'b0, "R8", "idle without request", 64'(bus_trans), 0);
    summary();
  end
endmodule